// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside the page loader of a byte-programmable flash array and watches every byte-load write. It spots the multi-write command codes used to switch write protection, enter or leave an identification mode and lock either boot region. For each write it makes the decision the loader needs: whether this byte is a command write, and whether ordinary data may go into the page buffer.

All codes share one two-write prefix. Protection turns on or off only when the loader reports the end of a program period. Identification mode replaces array read data with fixed codes and with the lock status of the two boot regions.

There are two resets. A cold reset stands for the first power-up of the persistent cells and clears everything. A power-on reset clears only the volatile state, which is the decoder, the identification mode and the unlock window. The protection bit and both lock bits survive it.

Top module: `unlock_decoder`

## Requirements
- R1: Command addresses are matched on write address bits 14..0 only. Bits above 14 do not matter, so AA written to 0x1D555 counts as the first prefix write.
- R2: The writes AA@5555, 55@2AAA, A0@5555 open an unlock window. The loads that follow are written (`byte_wen`=1). Protection becomes active at the next `prog_done` pulse. After that a plain load gives `byte_wen`=0.
- R3: While protection is active, a load gives `byte_wen`=1 only inside an unlock window opened by AA@5555, 55@2AAA, A0@5555. The window closes at `prog_done`.
- R4: The six writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 open a window and clear protection at the next `prog_done`. Plain loads after that give `byte_wen`=1.
- R5: The prefix followed by 90@5555 enters identification mode, and the prefix followed by F0@5555 leaves it. In identification mode, reads of address 0 return 1F and reads of address 1 return D5. Other addresses that carry no lock status pass `arr_rdata` through.
- R6: The prefix, then 80, AA, 55, 40 (at 5555, 5555, 2AAA, 5555), then 00@0x00000 locks the low boot region. Ending with FF@0x1FFFF instead locks the high region. In identification mode, address 0x00002 reports the low lock and 0x1FFF2 reports the high lock, as FE when unlocked and FF when locked.
- R7: A locked region (low: address bits 16..13 all zero; high: address bits 16..13 all one) gives `byte_wen`=0. `erase_ok` is 0 while either lock is set.
- R8: A write that does not match the expected next step sends the decoder back to idle. That write is treated as an ordinary load (`cmd_hit`=0).
- R9: `por_n` low clears identification mode and the decoder but keeps protection and the locks. `cold_rst_n` low clears all state.
- R10: A write that matches a command step gives `cmd_hit`=1 and `byte_wen`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Sync reset of the persistent and volatile state, active low |
| por_n | input | 1 | Sync reset of the volatile state only, active low |
| wr_stb | input | 1 | Byte-load write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 8 | Write data |
| prog_done | input | 1 | Pulse from the loader at the end of a program period |
| rd_addr | input | ADDR_W | Read byte address |
| arr_rdata | input | 8 | Read data from the array |
| rd_data | output | 8 | Read data after the identification override |
| byte_wen | output | 1 | Current write may enter the page buffer |
| cmd_hit | output | 1 | Current write is a command step |
| erase_ok | output | 1 | Chip erase is permitted |

## Verification
The bench builds the block with its defaults, ADDR_W=17 and BOOT_W=13. This puts the 8 KB boot regions at both ends of a 128 KB space. The all-ones lock address 0x1FFFF and the status address 0x1FFF2 therefore land at the top of the high region. These values also leave bits 16 and 15 free, so the bench can show that command matching ignores them. With the two regions only 4 address bits wide at the top, the bench can probe both edges and the middle with a few writes.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE1, ST_PRE2, ST_EXT3, ST_EXT4, ST_EXT5, ST_LKWAIT
  } seq_t;

  localparam logic [14:0] CA_ODD  = 15'h5555;
  localparam logic [14:0] CA_EVEN = 15'h2AAA;
  localparam logic [7:0]  K_FIRST = 8'hAA;
  localparam logic [7:0]  K_SECND = 8'h55;
  localparam logic [7:0]  K_PROT  = 8'hA0;
  localparam logic [7:0]  K_IDIN  = 8'h90;
  localparam logic [7:0]  K_IDOUT = 8'hF0;
  localparam logic [7:0]  K_EXT   = 8'h80;
  localparam logic [7:0]  K_UNPR  = 8'h20;
  localparam logic [7:0]  K_LOCK  = 8'h40;
  localparam logic [7:0]  ID_MFR  = 8'h1F;
  localparam logic [7:0]  ID_DEV  = 8'hD5;

  // true when a write hits the expected command step
  function automatic logic step_ok(input logic [14:0] a, input logic [7:0] d,
                                   input logic [14:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  // lock status byte: FE free, FF locked
  function automatic logic [7:0] lock_code(input logic locked);
    return {7'h7F, locked};
  endfunction
endpackage

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              soft_rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              cmd_hit,
  output logic              ev_prot,
  output logic              ev_unprot,
  output logic              ev_id_in,
  output logic              ev_id_out,
  output logic              ev_lk_lo,
  output logic              ev_lk_hi
);
  seq_t st, st_nxt;
  logic [14:0] ca;
  assign ca = wr_addr[14:0];

  always_comb begin
    st_nxt    = st;
    cmd_hit   = 1'b0;
    ev_prot   = 1'b0;
    ev_unprot = 1'b0;
    ev_id_in  = 1'b0;
    ev_id_out = 1'b0;
    ev_lk_lo  = 1'b0;
    ev_lk_hi  = 1'b0;
    if (wr_stb) begin
      st_nxt = ST_IDLE;
      unique case (st)
        ST_IDLE:
          if (step_ok(ca, wr_data, CA_ODD, K_FIRST)) begin cmd_hit = 1'b1; st_nxt = ST_PRE1; end
        ST_PRE1:
          if (step_ok(ca, wr_data, CA_EVEN, K_SECND)) begin cmd_hit = 1'b1; st_nxt = ST_PRE2; end
        ST_PRE2:
          if (ca == CA_ODD) begin
            case (wr_data)
              K_PROT:  begin cmd_hit = 1'b1; ev_prot   = 1'b1; end
              K_IDIN:  begin cmd_hit = 1'b1; ev_id_in  = 1'b1; end
              K_IDOUT: begin cmd_hit = 1'b1; ev_id_out = 1'b1; end
              K_EXT:   begin cmd_hit = 1'b1; st_nxt = ST_EXT3; end
              default: ;
            endcase
          end
        ST_EXT3:
          if (step_ok(ca, wr_data, CA_ODD, K_FIRST)) begin cmd_hit = 1'b1; st_nxt = ST_EXT4; end
        ST_EXT4:
          if (step_ok(ca, wr_data, CA_EVEN, K_SECND)) begin cmd_hit = 1'b1; st_nxt = ST_EXT5; end
        ST_EXT5:
          if (step_ok(ca, wr_data, CA_ODD, K_UNPR)) begin
            cmd_hit = 1'b1; ev_unprot = 1'b1;
          end else if (step_ok(ca, wr_data, CA_ODD, K_LOCK)) begin
            cmd_hit = 1'b1; st_nxt = ST_LKWAIT;
          end
        ST_LKWAIT:
          if (wr_addr == '0 && wr_data == 8'h00) begin
            cmd_hit = 1'b1; ev_lk_lo = 1'b1;
          end else if (&wr_addr && wr_data == 8'hFF) begin
            cmd_hit = 1'b1; ev_lk_hi = 1'b1;
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!soft_rst_n) st <= ST_IDLE;
    else             st <= st_nxt;
  end
endmodule

// File: rtl/mode_regs.sv
module mode_regs (
  input  logic clk,
  input  logic cold_rst_n,
  input  logic por_n,
  input  logic prog_done,
  input  logic ev_prot,
  input  logic ev_unprot,
  input  logic ev_id_in,
  input  logic ev_id_out,
  input  logic ev_lk_lo,
  input  logic ev_lk_hi,
  output logic prot,
  output logic lock_lo,
  output logic lock_hi,
  output logic id_mode,
  output logic win
);
  logic pend_on, pend_off;

  // persistent cells: only the cold reset clears them
  always_ff @(posedge clk) begin
    if (!cold_rst_n) begin
      prot    <= 1'b0;
      lock_lo <= 1'b0;
      lock_hi <= 1'b0;
    end else begin
      if (prog_done && pend_on)       prot <= 1'b1;
      else if (prog_done && pend_off) prot <= 1'b0;
      if (ev_lk_lo) lock_lo <= 1'b1;
      if (ev_lk_hi) lock_hi <= 1'b1;
    end
  end

  // volatile state
  always_ff @(posedge clk) begin
    if (!cold_rst_n || !por_n) begin
      id_mode  <= 1'b0;
      win      <= 1'b0;
      pend_on  <= 1'b0;
      pend_off <= 1'b0;
    end else begin
      if (prog_done) begin
        win      <= 1'b0;
        pend_on  <= 1'b0;
        pend_off <= 1'b0;
      end
      if (ev_prot)   begin win <= 1'b1; pend_on <= 1'b1; pend_off <= 1'b0; end
      if (ev_unprot) begin win <= 1'b1; pend_on <= 1'b0; pend_off <= 1'b1; end
      if (ev_id_in)  id_mode <= 1'b1;
      if (ev_id_out) id_mode <= 1'b0;
    end
  end
endmodule

// File: rtl/id_read_mux.sv
module id_read_mux
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              id_mode,
  input  logic              lock_lo,
  input  logic              lock_hi,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rdata,
  output logic [7:0]        rd_data
);
  localparam logic [ADDR_W-1:0] A_MFR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DEV = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LLO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LHI = {{(ADDR_W-4){1'b1}}, 4'h2};

  always_comb begin
    rd_data = arr_rdata;
    if (id_mode) begin
      if (rd_addr == A_MFR)      rd_data = ID_MFR;
      else if (rd_addr == A_DEV) rd_data = ID_DEV;
      else if (rd_addr == A_LLO) rd_data = lock_code(lock_lo);
      else if (rd_addr == A_LHI) rd_data = lock_code(lock_hi);
    end
  end
endmodule

// File: rtl/unlock_decoder.sv
module unlock_decoder #(
  parameter int ADDR_W = 17,
  parameter int BOOT_W = 13
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              por_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              prog_done,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rdata,
  output logic [7:0]        rd_data,
  output logic              byte_wen,
  output logic              cmd_hit,
  output logic              erase_ok
);
  localparam int SEL_W = ADDR_W - BOOT_W;

  logic ev_prot, ev_unprot, ev_id_in, ev_id_out, ev_lk_lo, ev_lk_hi;
  logic prot, lock_lo, lock_hi, id_mode, win;
  logic in_lo, in_hi, blocked;

  cmd_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .soft_rst_n(cold_rst_n & por_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_hit(cmd_hit), .ev_prot(ev_prot), .ev_unprot(ev_unprot),
    .ev_id_in(ev_id_in), .ev_id_out(ev_id_out),
    .ev_lk_lo(ev_lk_lo), .ev_lk_hi(ev_lk_hi)
  );

  mode_regs u_regs (
    .clk(clk), .cold_rst_n(cold_rst_n), .por_n(por_n), .prog_done(prog_done),
    .ev_prot(ev_prot), .ev_unprot(ev_unprot), .ev_id_in(ev_id_in),
    .ev_id_out(ev_id_out), .ev_lk_lo(ev_lk_lo), .ev_lk_hi(ev_lk_hi),
    .prot(prot), .lock_lo(lock_lo), .lock_hi(lock_hi),
    .id_mode(id_mode), .win(win)
  );

  id_read_mux #(.ADDR_W(ADDR_W)) u_rmux (
    .id_mode(id_mode), .lock_lo(lock_lo), .lock_hi(lock_hi),
    .rd_addr(rd_addr), .arr_rdata(arr_rdata), .rd_data(rd_data)
  );

  assign in_lo   = (wr_addr[ADDR_W-1:BOOT_W] == {SEL_W{1'b0}});
  assign in_hi   = (wr_addr[ADDR_W-1:BOOT_W] == {SEL_W{1'b1}});
  assign blocked = (in_lo && lock_lo) || (in_hi && lock_hi);

  assign byte_wen = wr_stb && !cmd_hit && (!prot || win) && !blocked;
  assign erase_ok = !(lock_lo || lock_hi);
endmodule

// File: rtl/unlock_decoder_chk.sv
module unlock_decoder_chk #(
  parameter int ADDR_W = 17,
  parameter int BOOT_W = 13
) (
  input logic              clk,
  input logic              cold_rst_n,
  input logic              por_n,
  input logic              prog_done,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              byte_wen,
  input logic              cmd_hit,
  input logic              erase_ok,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              prot,
  input logic              lock_lo,
  input logic              lock_hi,
  input logic              id_mode
);
  // R10
  cmd_not_data_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    cmd_hit |-> !byte_wen);
  // R7
  lo_block_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (wr_stb && lock_lo && wr_addr[ADDR_W-1:BOOT_W] == '0) |-> !byte_wen);
  // R7
  erase_gate_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (lock_lo || lock_hi) |-> !erase_ok);
  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (lock_lo && lock_hi) |=> (lock_lo && lock_hi));
  // R9
  por_clears_id_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !por_n |=> !id_mode);
  // R9
  por_keeps_prot_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!por_n && !prog_done) |=> (prot == $past(prot)));
  // R5
  id_mfr_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (id_mode && rd_addr == '0) |-> (rd_data == 8'h1F));
endmodule

bind unlock_decoder unlock_decoder_chk #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .por_n(por_n), .prog_done(prog_done),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .byte_wen(byte_wen), .cmd_hit(cmd_hit),
  .erase_ok(erase_ok), .rd_addr(rd_addr), .rd_data(rd_data), .prot(prot),
  .lock_lo(lock_lo), .lock_hi(lock_hi), .id_mode(id_mode)
);

// File: tb/sim_unlock_decoder.sv
module sim_unlock_decoder;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          cold_rst_n = 1'b0, por_n = 1'b0;
  logic          wr_stb = 1'b0, prog_done = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]    wr_data = '0, arr_rdata = '0;
  logic [7:0]    rd_data;
  logic          byte_wen, cmd_hit, erase_ok;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t sb[$];
  event mon_ev;

  always #5 clk = ~clk;

  unlock_decoder u0 (
    .clk(clk), .cold_rst_n(cold_rst_n), .por_n(por_n), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
    .rd_addr(rd_addr), .arr_rdata(arr_rdata), .rd_data(rd_data),
    .byte_wen(byte_wen), .cmd_hit(cmd_hit), .erase_ok(erase_ok)
  );

  function automatic void push(input int k, input logic [7:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb.push_back(it);
  endfunction

  task automatic drain();
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = sb.pop_front();
      case (it.kind)
        0: got = {7'b0, byte_wen};
        1: got = {7'b0, cmd_hit};
        2: got = rd_data;
        default: got = {7'b0, erase_ok};
      endcase
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d got=%h exp=%h", it.tag, it.kind, got, it.exp);
      end
    end
  endtask

  initial forever begin
    @(mon_ev);
    drain();
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input logic ew, input logic ec, input string t);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_stb = 1'b1;
    #1;
    push(0, {7'b0, ew}, t);
    push(1, {7'b0, ec}, t);
    ->mon_ev;
    @(posedge clk);
    #1 wr_stb = 1'b0;
  endtask

  task automatic cmd(input logic [AW-1:0] a, input logic [7:0] d, input string t);
    wr(a, d, 1'b0, 1'b1, t);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] arr,
                    input logic [7:0] e, input string t);
    @(negedge clk);
    rd_addr = a; arr_rdata = arr;
    #1;
    push(2, e, t);
    ->mon_ev;
  endtask

  task automatic chk_erase(input logic e, input string t);
    @(negedge clk);
    #1;
    push(3, {7'b0, e}, t);
    ->mon_ev;
  endtask

  task automatic done_pulse();
    @(negedge clk); prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;
  endtask

  task automatic prefix(input string t);
    cmd(17'h05555, 8'hAA, t);
    cmd(17'h02AAA, 8'h55, t);
  endtask

  task automatic ext_prefix(input string t);
    prefix(t);
    cmd(17'h05555, 8'h80, t);
    cmd(17'h05555, 8'hAA, t);
    cmd(17'h02AAA, 8'h55, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1; por_n = 1'b1;
    // reset state
    chk_erase(1'b1, "R7 reset erase_ok");
    rd(17'h00000, 8'h3C, 8'h3C, "R5 reset passthrough");
    wr(17'h04000, 8'h12, 1'b1, 1'b0, "R8 plain load unprotected");
    // broken sequences
    cmd(17'h05555, 8'hAA, "R10 first step");
    wr(17'h04001, 8'h77, 1'b1, 1'b0, "R8 break after first");
    wr(17'h02AAA, 8'h55, 1'b1, 1'b0, "R8 second step from idle");
    prefix("R10 prefix");
    wr(17'h05555, 8'h33, 1'b1, 1'b0, "R8 bad third");
    // enable protection, high bits ignored
    cmd(17'h1D555, 8'hAA, "R1 high bits set");
    cmd(17'h0AAAA, 8'h55, "R1 high bits set");
    cmd(17'h05555, 8'hA0, "R2 enable");
    wr(17'h04080, 8'h11, 1'b1, 1'b0, "R2 load in window");
    wr(17'h04081, 8'h22, 1'b1, 1'b0, "R2 second load in window");
    done_pulse();
    wr(17'h04082, 8'h23, 1'b0, 1'b0, "R2 plain load after enable");
    // protected unlock window
    prefix("R3 unlock");
    cmd(17'h05555, 8'hA0, "R3 unlock");
    wr(17'h04100, 8'h44, 1'b1, 1'b0, "R3 unlocked load");
    done_pulse();
    wr(17'h04101, 8'h45, 1'b0, 1'b0, "R3 window closed");
    // identification mode
    prefix("R5 id entry");
    cmd(17'h05555, 8'h90, "R5 id entry");
    rd(17'h00000, 8'h00, 8'h1F, "R5 mfr code");
    rd(17'h00001, 8'h00, 8'hD5, "R5 dev code");
    rd(17'h00002, 8'h00, 8'hFE, "R6 low free");
    rd(17'h1FFF2, 8'h00, 8'hFE, "R6 high free");
    rd(17'h00100, 8'h5A, 8'h5A, "R5 other address");
    // power-on reset keeps protection, drops id
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rd(17'h00000, 8'h44, 8'h44, "R9 id cleared by por");
    wr(17'h04300, 8'h01, 1'b0, 1'b0, "R9 protection kept by por");
    // low boot lock
    ext_prefix("R6 lock low");
    cmd(17'h05555, 8'h40, "R6 lock low");
    cmd(17'h00000, 8'h00, "R6 lock low final");
    chk_erase(1'b0, "R7 erase gated");
    prefix("R6 id");
    cmd(17'h05555, 8'h90, "R6 id");
    rd(17'h00002, 8'h00, 8'hFF, "R6 low locked");
    rd(17'h1FFF2, 8'h00, 8'hFE, "R6 high still free");
    prefix("R5 id exit");
    cmd(17'h05555, 8'hF0, "R5 id exit");
    rd(17'h00000, 8'h66, 8'h66, "R5 exit passthrough");
    // disable protection
    ext_prefix("R4 disable");
    cmd(17'h05555, 8'h20, "R4 disable");
    wr(17'h04200, 8'h09, 1'b1, 1'b0, "R4 load after disable code");
    done_pulse();
    wr(17'h04201, 8'h0A, 1'b1, 1'b0, "R4 plain load after clear");
    // boot region blocking
    wr(17'h00010, 8'h01, 1'b0, 1'b0, "R7 low locked");
    wr(17'h1E010, 8'h01, 1'b1, 1'b0, "R7 high free");
    ext_prefix("R6 lock high");
    cmd(17'h05555, 8'h40, "R6 lock high");
    cmd(17'h1FFFF, 8'hFF, "R6 lock high final");
    wr(17'h1E010, 8'h01, 1'b0, 1'b0, "R7 high locked");
    wr(17'h08000, 8'h01, 1'b1, 1'b0, "R7 middle free");
    wr(17'h01FFF, 8'h01, 1'b0, 1'b0, "R7 low top edge");
    wr(17'h02000, 8'h01, 1'b1, 1'b0, "R7 above low region");
    // cold reset clears all
    @(negedge clk); cold_rst_n = 1'b0;
    @(negedge clk); cold_rst_n = 1'b1;
    chk_erase(1'b1, "R9 cold reset clears locks");
    wr(17'h00010, 8'h01, 1'b1, 1'b0, "R9 cold reset low writable");
    @(negedge clk);
    drain();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule